// File: doc/BRIEF.md
# Bi-Endian Byte-Addressable Load/Store Memory

This block is a small data memory organised as an array of 8-bit locations, one per address. A word-oriented front end lets a client load or store a single byte, a 2-byte halfword or a 4-byte word in one access. A run-time mode input selects the byte order for multi-byte accesses. In big-endian mode the highest-order byte sits at the lowest address. In little-endian mode the lowest-order byte sits there.

Stores commit on the rising clock edge. Loads are combinational from the current contents, and the loaded value is zero-extended to 32 bits. An access that is not naturally aligned raises an error flag in the same cycle, and a store flagged this way changes nothing. The same applies to an access using the reserved size code. Because the mode is applied at access time and not at store time, data written in one order and read in the other comes back byte-reversed.

Top module: `endian_lsu`

## Requirements
- R1: After reset every byte location holds 0x00, so any legal load returns 0.
- R2: With `big_end`=1, storing word 0x87654321 at address A places 0x87, 0x65, 0x43, 0x21 at addresses A, A+1, A+2, A+3 (A+0 receives bits 31:24). A halfword at A places bits 15:8 at A and bits 7:0 at A+1.
- R3: With `big_end`=0, storing word 0x87654321 at address A places 0x21, 0x43, 0x65, 0x87 at A..A+3 (A+0 receives bits 7:0). A halfword at A places bits 7:0 at A.
- R4: Size code 2'b00 is a byte, 2'b01 a halfword and 2'b10 a word. A legal byte load returns bits 31:8 as zero, and a legal halfword load returns bits 31:16 as zero.
- R5: `misalign` is 1 in the same cycle, with no clock edge needed, when a halfword has addr[0]=1, when a word has addr[1:0]≠0, or when the size is 2'b11. Otherwise it is 0. While `misalign` is 1, `rdata` is 0.
- R6: A store with `misalign`=1 leaves every byte location unchanged.
- R7: Size code 2'b11 is reserved. It is treated as an error at every address.
- R8: A legal store becomes visible only after the rising clock edge. Before that edge, a load of the same address in the same cycle returns the old contents.
- R9: The byte order is applied at load time. A word stored in one mode and loaded as a word in the other mode returns its four bytes in reversed order.
- R10: Single-byte stores and loads are independent of `big_end`. A byte stored in either mode reads back unchanged in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; stores commit on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset; clears all bytes |
| addr | input | AW (6) | Byte address of the lowest location accessed |
| size | input | 2 | Access size: 00 byte, 01 halfword, 10 word, 11 reserved |
| wr_en | input | 1 | 1 stores `wdata` at the next rising edge, 0 only loads |
| wdata | input | 32 | Store value, right-justified for byte and halfword |
| big_end | input | 1 | 1 big-endian lane order, 0 little-endian |
| rdata | output | 32 | Zero-extended load value, combinational |
| misalign | output | 1 | Alignment or size error for the current access |

## Verification
The hardest behaviour to reach from the ports is the cross-mode case. The bytes written in one order must be read back in the other, both as single bytes and as whole words, and this has to be done at every alignment. The bench reaches it with directed sequences that store the 0x87654321 pattern in each mode, then read each address as a byte and the base as a word in both modes. Random traffic then mixes modes, sizes and misaligned stores over a small array, so that later reads land on locations touched by earlier writes in the other mode.

// File: rtl/endian_lsu_pkg.sv
package endian_lsu_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    localparam int LANES = 4;

    typedef logic [LANES-1:0][7:0] lane_bytes_t;

endpackage

// File: rtl/lsu_align_check.sv
module lsu_align_check
    import endian_lsu_pkg::*;
(
    input  logic [1:0] addr_lo,
    input  logic [1:0] size,
    output logic [2:0] nbytes,
    output logic       err
);

    always_comb begin
        nbytes = 3'd0;
        err    = 1'b0;
        unique case (acc_size_e'(size))
            SZ_BYTE: nbytes = 3'd1;
            SZ_HALF: begin
                nbytes = 3'd2;
                err    = addr_lo[0];
            end
            SZ_WORD: begin
                nbytes = 3'd4;
                err    = |addr_lo;
            end
            default: err = 1'b1;
        endcase
    end

endmodule

// File: rtl/lsu_lane_map.sv
module lsu_lane_map
    import endian_lsu_pkg::*;
(
    input  logic [2:0]  nbytes,
    input  logic        ok,
    input  logic        wr_en,
    input  logic        big_end,
    input  logic [31:0] wdata,
    input  lane_bytes_t rd_lane,
    output logic [LANES-1:0] lane_we,
    output lane_bytes_t wr_lane,
    output logic [31:0] rdata
);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic       active;
        logic [1:0] idx;
        logic [2:0] rev;

        assign active = ok && (3'(k) < nbytes);
        assign rev    = nbytes - 3'd1 - 3'(k);
        assign idx    = big_end ? rev[1:0] : 2'(k);

        // memory lane k takes value byte idx; reversal is its own inverse
        assign wr_lane[k]       = 8'(wdata >> {idx, 3'b000});
        assign lane_we[k]       = active && wr_en;
        assign rdata[8*k +: 8]  = active ? rd_lane[idx] : 8'h00;
    end

endmodule

// File: rtl/lsu_byte_store.sv
module lsu_byte_store
    import endian_lsu_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    base,
    input  logic [LANES-1:0] we,
    input  lane_bytes_t      wr_lane,
    output lane_bytes_t      rd_lane
);

    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
    } store_t;

    store_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int k = 0; k < LANES; k++) begin
            if (we[k]) begin
                s_d.mem[base + AW'(k)] = wr_lane[k];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    for (genvar k = 0; k < LANES; k++) begin : g_rd
        assign rd_lane[k] = s_q.mem[base + AW'(k)];
    end

    // R8
    lane0_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we[0] |=> s_q.mem[$past(base)] == $past(wr_lane[0]));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we == '0) |=> $stable(s_q.mem));

endmodule

// File: rtl/endian_lsu.sv
module endian_lsu
    import endian_lsu_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic [1:0]    size,
    input  logic          wr_en,
    input  logic [31:0]   wdata,
    input  logic          big_end,
    output logic [31:0]   rdata,
    output logic          misalign
);

    logic [2:0]       nbytes;
    logic             err;
    logic [LANES-1:0] lane_we;
    lane_bytes_t      wr_lane;
    lane_bytes_t      rd_lane;

    lsu_align_check u_align (
        .addr_lo (addr[1:0]),
        .size    (size),
        .nbytes  (nbytes),
        .err     (err)
    );

    lsu_lane_map u_map (
        .nbytes  (nbytes),
        .ok      (!err),
        .wr_en   (wr_en),
        .big_end (big_end),
        .wdata   (wdata),
        .rd_lane (rd_lane),
        .lane_we (lane_we),
        .wr_lane (wr_lane),
        .rdata   (rdata)
    );

    lsu_byte_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .base    (addr),
        .we      (lane_we),
        .wr_lane (wr_lane),
        .rd_lane (rd_lane)
    );

    assign misalign = err;

    // R6
    misalign_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> lane_we == '0);

    // R5
    misalign_zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> rdata == 32'h0);

    // R4
    byte_zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (size == 2'b00) |-> rdata[31:8] == 24'h0);

    // R4
    half_zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (size == 2'b01) |-> rdata[31:16] == 16'h0);

    // R7
    rsvd_size_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (size == 2'b11) |-> misalign);

    // R5
    word_lane_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !misalign && size == 2'b10) |-> $countones(lane_we) == 4);

endmodule

// File: tb/endian_lsu_test.sv
module endian_lsu_test;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 64;
    localparam int AW         = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [1:0]    size = 2'b00;
    logic          wr_en = 1'b0;
    logic [31:0]   wdata = '0;
    logic          big_end = 1'b0;
    logic [31:0]   rdata;
    logic          misalign;

    logic [7:0] model [DEPTH];
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    endian_lsu #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .size(size), .wr_en(wr_en),
        .wdata(wdata), .big_end(big_end), .rdata(rdata), .misalign(misalign)
    );

    function automatic int nb(input logic [1:0] s);
        return (s == 2'b00) ? 1 : (s == 2'b01) ? 2 : (s == 2'b10) ? 4 : 0;
    endfunction

    function automatic logic bad(input int a, input logic [1:0] s);
        return (s == 2'b11) || (s == 2'b01 && a % 2 != 0) || (s == 2'b10 && a % 4 != 0);
    endfunction

    function automatic logic [31:0] exp_read(input int a, input logic [1:0] s, input logic be);
        logic [31:0] r = '0;
        int n = nb(s);
        if (bad(a, s)) return '0;
        for (int j = 0; j < n; j++) begin
            r[8*j +: 8] = model[be ? a + n - 1 - j : a + j];
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input int a, input logic [1:0] s, input logic [31:0] d,
                            input logic be, input string req);
        @(negedge clk);
        addr = AW'(a); size = s; wdata = d; big_end = be; wr_en = 1'b1;
        #1;
        check({req, " err flag on store"}, {31'b0, misalign}, {31'b0, bad(a, s)});
        @(posedge clk);
        if (!bad(a, s)) begin
            for (int j = 0; j < nb(s); j++) begin
                model[be ? a + nb(s) - 1 - j : a + j] = d[8*j +: 8];
            end
        end
        #1;
        wr_en = 1'b0;
    endtask

    task automatic do_read(input int a, input logic [1:0] s, input logic be, input string req);
        @(negedge clk);
        addr = AW'(a); size = s; big_end = be; wr_en = 1'b0;
        #1;
        check(req, rdata, exp_read(a, s, be));
        check({req, " err flag"}, {31'b0, misalign}, {31'b0, bad(a, s)});
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
        #(CLK_PERIOD * 2 + 3);
        rst_n = 1'b1;

        // R1: reset contents read as zero
        do_read(0, 2'b10, 1'b1, "R1 word@0");
        do_read(60, 2'b10, 1'b0, "R1 word@60");

        // R2: big-endian layout of the example value
        do_write(0, 2'b10, 32'h87654321, 1'b1, "R2");
        do_read(0, 2'b00, 1'b1, "R2 byte0"); check("R2 byte0=87", rdata, 32'h87);
        do_read(3, 2'b00, 1'b0, "R2 byte3"); check("R2 byte3=21", rdata, 32'h21);
        do_read(1, 2'b00, 1'b1, "R2 byte1");
        do_read(2, 2'b00, 1'b0, "R2 byte2");
        // R9: opposite mode reverses
        do_read(0, 2'b10, 1'b0, "R9 word LE view"); check("R9 reversed", rdata, 32'h21436587);
        do_read(0, 2'b10, 1'b1, "R2 word BE view"); check("R2 roundtrip", rdata, 32'h87654321);

        // R3: little-endian layout
        do_write(4, 2'b10, 32'h87654321, 1'b0, "R3");
        do_read(4, 2'b00, 1'b1, "R3 byte4"); check("R3 byte4=21", rdata, 32'h21);
        do_read(7, 2'b00, 1'b0, "R3 byte7"); check("R3 byte7=87", rdata, 32'h87);
        do_read(4, 2'b10, 1'b1, "R9 word BE view"); check("R9 reversed BE", rdata, 32'h21436587);
        do_write(8, 2'b01, 32'hFFFFBEEF, 1'b1, "R2 half");
        do_read(8, 2'b00, 1'b0, "R2 half hi byte"); check("R2 half byte8=BE", rdata, 32'hBE);
        do_read(8, 2'b01, 1'b0, "R9 half LE view"); check("R9 half swapped", rdata, 32'hEFBE);

        // R4: zero extension
        do_write(12, 2'b10, 32'hF1F2F3F4, 1'b0, "R4 setup");
        do_read(13, 2'b00, 1'b1, "R4 byte"); check("R4 byte zext", rdata, 32'hF3);
        do_read(14, 2'b01, 1'b0, "R4 half"); check("R4 half zext", rdata, 32'hF1F2);

        // R5/R6: misaligned accesses
        do_write(13, 2'b10, 32'hDEADBEEF, 1'b1, "R6 word@13");
        do_write(15, 2'b01, 32'h0000AAAA, 1'b0, "R6 half@15");
        do_read(12, 2'b10, 1'b0, "R6 word unchanged"); check("R6 still F1F2F3F4", rdata, 32'hF1F2F3F4);
        do_read(16, 2'b10, 1'b0, "R6 next word unchanged");
        do_read(2, 2'b10, 1'b1, "R5 word@2");
        do_read(9, 2'b01, 1'b1, "R5 half@9");

        // R7: reserved size
        do_write(20, 2'b11, 32'h55555555, 1'b0, "R7 store");
        do_read(20, 2'b11, 1'b0, "R7 load");
        do_read(20, 2'b10, 1'b0, "R7 word unchanged"); check("R7 zero", rdata, 32'h0);

        // R8: write visible only after the edge
        @(negedge clk);
        addr = AW'(24); size = 2'b10; wdata = 32'hCAFEF00D; big_end = 1'b1; wr_en = 1'b1;
        #1;
        check("R8 old value before edge", rdata, 32'h0);
        @(posedge clk);
        for (int j = 0; j < 4; j++) model[24 + 3 - j] = 8'(32'hCAFEF00D >> (8*j));
        #1;
        check("R8 new value after edge", rdata, 32'hCAFEF00D);
        wr_en = 1'b0;

        // R10: bytes are mode independent
        do_write(30, 2'b00, 32'h0000005A, 1'b1, "R10");
        do_read(30, 2'b00, 1'b0, "R10 LE"); check("R10 5A", rdata, 32'h5A);
        do_read(30, 2'b00, 1'b1, "R10 BE");

        // R9: random mixed traffic against the model
        for (int i = 0; i < 400; i++) begin
            int a = int'($urandom % DEPTH);
            logic [1:0] s = 2'($urandom);
            logic be = 1'($urandom);
            if ($urandom % 2 == 0) do_write(a, s, $urandom, be, "R9 rand");
            else do_read(a, s, be, "R9 rand");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule